// File: doc/BRIEF.md
# Core Debug Command Controller

This block lets an external debug transport steer a processor core through a small command channel. Each command carries a write flag, an 8-bit address and a 32-bit data word. A command moves on a valid/ready handshake. One cycle after it is accepted, a response strobe and its read data appear. Two addresses are decoded:

- A control/status word holds four flags: reset request, halt, halted-by-breakpoint and single-step.
- An instruction word returns the last value the core wrote into its register file. Writing it pushes an instruction into the halted core.

Toward the core, the block drives halt, step and a reset request. The reset request can reset the core and the logic around it. The block has its own debug reset, so the core reset does not disturb it.

Injected instructions pass through a small state machine with two states:

- `ST_IDLE` is the default. An instruction write seen there moves the machine to `ST_INJECT` and captures the word.
- In `ST_INJECT` the captured word is offered to the core on `inj_valid`/`inj_instr`.
- The transition from `ST_INJECT` back to `ST_IDLE` happens in the cycle the core raises `inj_ready`. In that same cycle the command is accepted.

Every other command is accepted at once in `ST_IDLE`.

Top module: `dbg_ctrl_core`

## Requirements
- R1: A command is accepted in a cycle where both `cmd_valid` and `cmd_ready` are high. `rsp_valid` is high in the next cycle and only then. In that cycle `rsp_rdata` holds the read result, or zero after a write.
- R2: A read of address 0x00 returns the reset request in bit 0, halt in bit 1, the `core_busy` input in bit 2, halted-by-breakpoint in bit 3 and single-step in bit 4. All other bits read zero.
- R3: A write to address 0x00 loads single-step from data bit 4. A 1 in data bit 16 sets the reset request. A 1 in data bit 17 sets halt.
- R4: A write to address 0x00 with a 1 in bit 24 clears the reset request. A 1 in bit 25 clears both halt and halted-by-breakpoint. If the set bit and the clear bit of one flag are both 1 in the same write, the flag ends cleared.
- R5: A read of address 0x04 returns the data of the most recent `rf_wr_en` cycle before the accepted cycle. After a debug reset it returns zero.
- R6: A write to address 0x04 is not accepted (`cmd_ready` low) until the core takes the instruction. While the core withholds `inj_ready`, `inj_valid` stays high with `inj_instr` equal to the write data. The command is accepted in the cycle `inj_ready` is high. The write changes no flag and not the captured register-file value.
- R7: A `bkpt_hit` pulse sets both halted-by-breakpoint and halt. Halted-by-breakpoint is never set while halt is clear.
- R8: While single-step is set and halt is clear, a `core_retire` pulse sets halt. With single-step clear, retire pulses leave halt unchanged.
- R9: `core_halt`, `core_step` and `rst_req` follow the halt, single-step and reset-request flags. A low `dbg_rst_n` clears all flags and the captured register-file value.
- R10: Reads of any other address return zero. Writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| dbg_rst_n | input | 1 | Debug-side reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Response data |
| core_halt | output | 1 | Hold the core |
| core_step | output | 1 | Single-step mode flag |
| rst_req | output | 1 | Reset request to core and surroundings |
| inj_valid | output | 1 | Injected instruction offered |
| inj_ready | input | 1 | Core takes the injected instruction |
| inj_instr | output | 32 | Injected instruction word |
| core_busy | input | 1 | Pipeline still has work in flight |
| bkpt_hit | input | 1 | Breakpoint reached |
| core_retire | input | 1 | One instruction retired |
| rf_wr_en | input | 1 | Register file write strobe |
| rf_wr_data | input | 32 | Register file write data |

## Verification
The embedded properties check the following on every cycle:

- the response strobe follows acceptance exactly one cycle later;
- an offered instruction holds steady until the core takes it;
- an instruction write is never accepted without the core's ready;
- the clear bits win over the set bits and over a simultaneous breakpoint;
- a breakpoint halts and marks the core;
- a retire in step mode re-halts;
- halted-by-breakpoint never stands without halt.

Only the directed scenarios show the rest:

- the exact bit layout of the status word;
- the register-file capture read back through address 0x04;
- the absence of side effects from injection and from unmapped addresses;
- the complete clearing by a debug reset in mid-run.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 32;

    localparam int CTRL_OFS = 'h00;
    localparam int INSN_OFS = 'h04;

    // status read bit positions
    localparam int RD_RST  = 0;
    localparam int RD_HALT = 1;
    localparam int RD_BUSY = 2;
    localparam int RD_BRK  = 3;
    localparam int RD_STEP = 4;

    // control write bit positions
    localparam int WR_STEP     = 4;
    localparam int WR_SET_RST  = 16;
    localparam int WR_SET_HALT = 17;
    localparam int WR_CLR_RST  = 24;
    localparam int WR_CLR_HALT = 25;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_INJECT = 1'b1
    } inj_state_t;

    typedef struct packed {
        logic step;
        logic set_rst;
        logic set_halt;
        logic clr_rst;
        logic clr_halt;
    } ctrl_fields_t;
endpackage

// File: rtl/dbg_cmd_fsm.sv
module dbg_cmd_fsm
    import dbg_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_inj,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              inj_ready,
    output logic              cmd_ready,
    output logic              inj_valid,
    output logic [DATA_W-1:0] inj_instr
);
    inj_state_t state_q, state_d;
    logic [DATA_W-1:0] instr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            instr_q <= '0;
        else if (state_q == ST_IDLE && cmd_valid && cmd_is_inj)
            instr_q <= cmd_wdata;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid && cmd_is_inj) state_d = ST_INJECT;
            ST_INJECT: if (inj_ready)               state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready = 1'b0;
        inj_valid = 1'b0;
        inj_instr = instr_q;
        unique case (state_q)
            ST_IDLE:   cmd_ready = !cmd_is_inj;
            ST_INJECT: begin
                inj_valid = 1'b1;
                cmd_ready = inj_ready;
            end
            default: ;
        endcase
    end

    // R6
    inj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid && !inj_ready |=> inj_valid && $stable(inj_instr));

    // R6
    inj_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_is_inj && cmd_ready |-> inj_valid && inj_ready);
endmodule

// File: rtl/dbg_flag_regs.sv
module dbg_flag_regs
    import dbg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  ctrl_fields_t fields,
    input  logic         bkpt_hit,
    input  logic         retire,
    output logic         reset_f,
    output logic         halt_f,
    output logic         brk_f,
    output logic         step_f
);
    logic r_d, h_d, b_d, s_d;

    always_comb begin
        r_d = reset_f;
        h_d = halt_f;
        b_d = brk_f;
        s_d = step_f;
        if (bkpt_hit) begin
            h_d = 1'b1;
            b_d = 1'b1;
        end
        if (step_f && !halt_f && retire) h_d = 1'b1;
        if (ctrl_wr) begin
            s_d = fields.step;
            if (fields.set_rst)  r_d = 1'b1;
            if (fields.set_halt) h_d = 1'b1;
            if (fields.clr_rst)  r_d = 1'b0;
            if (fields.clr_halt) begin
                h_d = 1'b0;
                b_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_f <= 1'b0;
            halt_f  <= 1'b0;
            brk_f   <= 1'b0;
            step_f  <= 1'b0;
        end else begin
            reset_f <= r_d;
            halt_f  <= h_d;
            brk_f   <= b_d;
            step_f  <= s_d;
        end
    end

    // R3
    step_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> step_f == $past(fields.step));

    // R4
    clr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && fields.clr_halt |=> !halt_f && !brk_f);

    // R4
    clr_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && fields.clr_rst |=> !reset_f);

    // R7
    bkpt_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit && !(ctrl_wr && fields.clr_halt) |=> halt_f && brk_f);

    // R7
    brk_implies_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_f |-> halt_f);

    // R8
    step_rehalt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_f && !halt_f && retire && !(ctrl_wr && fields.clr_halt) |=> halt_f);
endmodule

// File: rtl/dbg_rf_snoop.sv
module dbg_rf_snoop
    import dbg_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_wr_en,
    input  logic [DATA_W-1:0] rf_wr_data,
    output logic [DATA_W-1:0] last_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)        last_q <= '0;
        else if (rf_wr_en) last_q <= rf_wr_data;
    end

    // R5
    rf_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> last_q == $past(rf_wr_data));
endmodule

// File: rtl/dbg_ctrl_core.sv
module dbg_ctrl_core
    import dbg_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              dbg_rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              core_halt,
    output logic              core_step,
    output logic              rst_req,
    output logic              inj_valid,
    input  logic              inj_ready,
    output logic [DATA_W-1:0] inj_instr,
    input  logic              core_busy,
    input  logic              bkpt_hit,
    input  logic              core_retire,
    input  logic              rf_wr_en,
    input  logic [DATA_W-1:0] rf_wr_data
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_INSN = ADDR_W'(INSN_OFS);

    logic hit_ctrl, hit_insn, is_inj, accept, ctrl_wr;
    logic reset_f, halt_f, brk_f, step_f;
    logic [DATA_W-1:0] last_rf, status, rd_mux;
    ctrl_fields_t fields;

    assign hit_ctrl = (cmd_addr == A_CTRL);
    assign hit_insn = (cmd_addr == A_INSN);
    assign is_inj   = cmd_write && hit_insn;
    assign accept   = cmd_valid && cmd_ready;
    assign ctrl_wr  = accept && cmd_write && hit_ctrl;

    assign fields.step     = cmd_wdata[WR_STEP];
    assign fields.set_rst  = cmd_wdata[WR_SET_RST];
    assign fields.set_halt = cmd_wdata[WR_SET_HALT];
    assign fields.clr_rst  = cmd_wdata[WR_CLR_RST];
    assign fields.clr_halt = cmd_wdata[WR_CLR_HALT];

    dbg_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (dbg_rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_is_inj (is_inj),
        .cmd_wdata  (cmd_wdata),
        .inj_ready  (inj_ready),
        .cmd_ready  (cmd_ready),
        .inj_valid  (inj_valid),
        .inj_instr  (inj_instr)
    );

    dbg_flag_regs u_flags (
        .clk      (clk),
        .rst_n    (dbg_rst_n),
        .ctrl_wr  (ctrl_wr),
        .fields   (fields),
        .bkpt_hit (bkpt_hit),
        .retire   (core_retire),
        .reset_f  (reset_f),
        .halt_f   (halt_f),
        .brk_f    (brk_f),
        .step_f   (step_f)
    );

    dbg_rf_snoop #(.DATA_W(DATA_W)) u_snoop (
        .clk        (clk),
        .rst_n      (dbg_rst_n),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_data (rf_wr_data),
        .last_q     (last_rf)
    );

    always_comb begin
        status          = '0;
        status[RD_RST]  = reset_f;
        status[RD_HALT] = halt_f;
        status[RD_BUSY] = core_busy;
        status[RD_BRK]  = brk_f;
        status[RD_STEP] = step_f;
        if (cmd_write)     rd_mux = '0;
        else if (hit_ctrl) rd_mux = status;
        else if (hit_insn) rd_mux = last_rf;
        else               rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (!dbg_rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) rsp_rdata <= rd_mux;
        end
    end

    assign core_halt = halt_f;
    assign core_step = step_f;
    assign rst_req   = reset_f;

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
        accept |=> rsp_valid);

    // R1
    rsp_spurious_chk: assert property (@(posedge clk) disable iff (!dbg_rst_n)
        !accept |=> !rsp_valid);
endmodule

// File: tb/dbg_ctrl_core_tb_top.sv
module dbg_ctrl_core_tb_top;
    logic        clk = 1'b0;
    logic        dbg_rst_n;
    logic        cmd_valid, cmd_write;
    logic        cmd_ready;
    logic [7:0]  cmd_addr;
    logic [31:0] cmd_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        core_halt, core_step, rst_req;
    logic        inj_valid, inj_ready;
    logic [31:0] inj_instr;
    logic        core_busy, bkpt_hit, core_retire, rf_wr_en;
    logic [31:0] rf_wr_data;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dbg_ctrl_core dut_i (
        .clk(clk), .dbg_rst_n(dbg_rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .core_halt(core_halt), .core_step(core_step), .rst_req(rst_req),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_instr(inj_instr),
        .core_busy(core_busy), .bkpt_hit(bkpt_hit), .core_retire(core_retire),
        .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic do_cmd(input logic wr, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        #1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        chk("R1 rsp_valid after accept", {31'b0, rsp_valid}, 32'd1);
        rd = rsp_rdata;
        cmd_valid = 1'b0; cmd_write = 1'b0;
        @(negedge clk);
        chk("R1 rsp_valid single pulse", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        logic [31:0] rd;
        do_cmd(1'b1, 8'h00, d, rd);
        chk("R1 write returns zero", rd, 32'h0);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd;
        do_cmd(1'b0, a, 32'h0, rd);
        chk(req, rd, exp);
    endtask

    task automatic pulse_bkpt();
        bkpt_hit = 1'b1; @(negedge clk); bkpt_hit = 1'b0;
    endtask

    task automatic pulse_retire();
        core_retire = 1'b1; @(negedge clk); core_retire = 1'b0;
    endtask

    task automatic rf_write(input logic [31:0] d);
        rf_wr_en = 1'b1; rf_wr_data = d; @(negedge clk); rf_wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R9 halt after reset", {31'b0, core_halt}, 32'd0);
        chk("R9 step after reset", {31'b0, core_step}, 32'd0);
        chk("R9 rst_req after reset", {31'b0, rst_req}, 32'd0);
        chk("R6 inj_valid after reset", {31'b0, inj_valid}, 32'd0);
        rd_chk("R2 status after reset", 8'h00, 32'h0);
    endtask

    task automatic t_set_and_layout();
        wr_ctrl(32'h0002_0000);
        chk("R3 halt set", {31'b0, core_halt}, 32'd1);
        rd_chk("R2 status halt", 8'h00, 32'h2);
        core_busy = 1'b1;
        rd_chk("R2 status busy bit", 8'h00, 32'h6);
        core_busy = 1'b0;
        wr_ctrl(32'h0001_0010);
        chk("R9 rst_req follows", {31'b0, rst_req}, 32'd1);
        chk("R9 core_step follows", {31'b0, core_step}, 32'd1);
        rd_chk("R3 status reset+halt+step", 8'h00, 32'h13);
    endtask

    task automatic t_clear_priority();
        wr_ctrl(32'h0303_0000);
        rd_chk("R4 clear wins over set", 8'h00, 32'h0);
        chk("R4 rst_req cleared", {31'b0, rst_req}, 32'd0);
    endtask

    task automatic t_breakpoint();
        pulse_bkpt();
        chk("R7 breakpoint halts", {31'b0, core_halt}, 32'd1);
        rd_chk("R7 status brk+halt", 8'h00, 32'hA);
        wr_ctrl(32'h0200_0000);
        rd_chk("R4 clear halt clears brk", 8'h00, 32'h0);
    endtask

    task automatic t_step();
        wr_ctrl(32'h0000_0010);
        rd_chk("R3 step only", 8'h00, 32'h10);
        pulse_retire();
        chk("R8 retire re-halts", {31'b0, core_halt}, 32'd1);
        rd_chk("R8 status after retire", 8'h00, 32'h12);
        wr_ctrl(32'h0200_0000);
        pulse_retire();
        rd_chk("R8 retire without step", 8'h00, 32'h0);
    endtask

    task automatic t_rf_capture();
        rf_write(32'hDEAD_BEEF);
        rd_chk("R5 rf capture", 8'h04, 32'hDEAD_BEEF);
        rf_write(32'h1111_2222);
        rf_write(32'h1234_5678);
        rd_chk("R5 rf latest", 8'h04, 32'h1234_5678);
    endtask

    task automatic t_inject();
        wr_ctrl(32'h0002_0000);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 8'h04; cmd_wdata = 32'h0050_0093;
        inj_ready = 1'b0;
        #1;
        chk("R6 not ready in idle", {31'b0, cmd_ready}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 inj_valid held", {31'b0, inj_valid}, 32'd1);
            chk("R6 inj_instr", inj_instr, 32'h0050_0093);
            chk("R6 cmd stalled", {31'b0, cmd_ready}, 32'd0);
        end
        inj_ready = 1'b1;
        #1;
        chk("R6 accept with inj_ready", {31'b0, cmd_ready}, 32'd1);
        @(negedge clk);
        chk("R1 inject rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R6 inj_valid dropped", {31'b0, inj_valid}, 32'd0);
        cmd_valid = 1'b0; cmd_write = 1'b0; inj_ready = 1'b0;
        @(negedge clk);
        rd_chk("R6 flags untouched", 8'h00, 32'h2);
        rd_chk("R6 rf value untouched", 8'h04, 32'h1234_5678);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd;
        rd_chk("R10 unmapped read", 8'h08, 32'h0);
        do_cmd(1'b1, 8'h08, 32'hFFFF_FFFF, rd);
        rd_chk("R10 unmapped write ignored", 8'h00, 32'h2);
    endtask

    task automatic t_debug_reset();
        wr_ctrl(32'h0001_0010);
        rd_chk("R3 before debug reset", 8'h00, 32'h13);
        dbg_rst_n = 1'b0;
        @(negedge clk);
        dbg_rst_n = 1'b1;
        chk("R9 halt cleared", {31'b0, core_halt}, 32'd0);
        chk("R9 rst_req cleared", {31'b0, rst_req}, 32'd0);
        chk("R9 step cleared", {31'b0, core_step}, 32'd0);
        @(negedge clk);
        rd_chk("R9 status cleared", 8'h00, 32'h0);
        rd_chk("R5 rf cleared by debug reset", 8'h04, 32'h0);
    endtask

    initial begin
        dbg_rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = 8'h0; cmd_wdata = 32'h0;
        inj_ready = 1'b0; core_busy = 1'b0; bkpt_hit = 1'b0; core_retire = 1'b0;
        rf_wr_en = 1'b0; rf_wr_data = 32'h0;
        repeat (3) @(negedge clk);
        dbg_rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_set_and_layout();
        t_clear_priority();
        t_breakpoint();
        t_step();
        t_rf_capture();
        t_inject();
        t_unmapped();
        t_debug_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule